// File: doc/BRIEF.md
# Instruction Fetch Next-PC Unit

This block keeps the program counter of a single-cycle processor and picks the address of the next instruction on every rising clock edge. The counter is stored as a word address. The byte address sent to instruction memory is that word address with two zero bits appended. There are three ways to move on: step to the following word, take a PC-relative conditional branch when the branch control and the ALU zero flag are both high, or make an absolute jump. An absolute jump keeps the top four address bits of the current PC and replaces the rest with a 26-bit target field taken from the instruction.

The decoder drives the branch and jump controls and the ALU drives the zero flag, all in the same cycle that the instruction is on the `instr` input. The 16-bit offset and the 26-bit target are taken from fixed fields of that instruction word. Instruction memory, decoding and exception vectors are outside this block.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the PC is loaded with 0, so `imem_addr` reads 0x00000000 after that edge. This holds whatever the control inputs are.
- R2: `imem_addr[1:0]` is always 00, and `imem_addr` equals the stored word address times 4.
- R3: When `branch_en` and `jump_en` are both 0, each rising edge advances `imem_addr` by 4.
- R4: When `branch_en` is 1, `alu_zero` is 0 and `jump_en` is 0, `imem_addr` advances by 4.
- R5: When `branch_en` and `alu_zero` are both 1 and `jump_en` is 0, the next address is the current address + 4 + 4 × imm, where imm is `instr[15:0]` read as a two's-complement value. Negative offsets move backwards.
- R6: When `jump_en` is 1, the next address is {current `imem_addr[31:28]`, `instr[25:0]`, 2'b00}.
- R7: When `jump_en` is 1, the jump is taken even if `branch_en` and `alu_zero` are both 1.
- R8: `alu_zero` has no effect while `branch_en` is 0: the address still advances by 4.
- R9: Address arithmetic wraps modulo 2^32. A sequential step from 0xFFFFFFFC gives 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr | input | 32 | Current instruction; bits 15:0 are the branch offset and bits 25:0 are the jump target |
| branch_en | input | 1 | Conditional branch control from the decoder |
| jump_en | input | 1 | Absolute jump control from the decoder |
| alu_zero | input | 1 | Zero flag from the ALU |
| imem_addr | output | 32 | Byte address of the current instruction |

## Verification
Straight-line stepping checks that the incrementer runs on its own. Branch with the zero flag low, and the zero flag high with branch low, tell a qualified branch apart from either control acting alone. Taken branches with positive, negative and most-negative offsets show the sign extension and the word scaling, and a branch that lands on the top word, followed by one sequential step, shows wrap-around. Jumps from a PC whose top nibble is 0 and from one whose top nibble is F show which bits are kept, and a jump asserted together with a taken branch shows the priority.

// File: rtl/pcseq_pkg.sv
// Package pcseq_pkg
// Shared widths for the next-PC unit. The word-address width and the
// number of preserved upper bits are derived from the byte-address width.
package pcseq_pkg;
    localparam int ADDR_W     = 32;
    localparam int BYTE_SEL_W = 2;
    localparam int IMM_W      = 16;
    localparam int TGT_W      = 26;
    localparam int INSTR_W    = 32;
    localparam int WORD_W     = ADDR_W - BYTE_SEL_W;
    localparam int KEEP_W     = WORD_W - TGT_W;
endpackage

// File: rtl/pc_word_reg.sv
// Module pc_word_reg
// Holds the word-address program counter. Assumes a synchronous,
// active-low reset that loads word address 0.
module pc_word_reg #(
    parameter int WORD_W = pcseq_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] next_pc,
    output logic [WORD_W-1:0] pc_q
);
    // Register the chosen next word address, or clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= next_pc;
    end

    // R1: a reset edge leaves the PC at word 0
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> pc_q == '0);
endmodule

// File: rtl/pc_adders.sv
// Module pc_adders
// Produces the sequential word address (PC + 1) and the branch target
// (PC + 1 + sign-extended offset). Offsets are in words, so no shift is
// needed. Assumes WORD_W > IMM_W.
module pc_adders #(
    parameter int WORD_W = pcseq_pkg::WORD_W,
    parameter int IMM_W  = pcseq_pkg::IMM_W
) (
    input  logic [WORD_W-1:0] pc_q,
    input  logic [IMM_W-1:0]  imm,
    output logic [WORD_W-1:0] seq_pc,
    output logic [WORD_W-1:0] br_pc
);
    localparam int EXT_W = WORD_W - IMM_W;

    logic [WORD_W-1:0] imm_ext;

    // Sign-extend the offset and form both candidate addresses.
    always_comb begin
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        seq_pc  = pc_q + WORD_W'(1);
        br_pc   = seq_pc + imm_ext;
    end
endmodule

// File: rtl/pc_next_sel.sv
// Module pc_next_sel
// Two-level choice of the next word address: the branch multiplexer first,
// then the jump multiplexer, which has the last word. A jump keeps the
// upper bits of the current PC above the target field.
module pc_next_sel #(
    parameter int WORD_W = pcseq_pkg::WORD_W,
    parameter int TGT_W  = pcseq_pkg::TGT_W
) (
    input  logic [WORD_W-1:0] pc_q,
    input  logic [WORD_W-1:0] seq_pc,
    input  logic [WORD_W-1:0] br_pc,
    input  logic [TGT_W-1:0]  target,
    input  logic              branch_en,
    input  logic              alu_zero,
    input  logic              jump_en,
    output logic [WORD_W-1:0] next_pc
);
    logic [WORD_W-1:0] after_br;

    // Branch mux: taken only when branch and zero are both set.
    always_comb begin
        after_br = (branch_en && alu_zero) ? br_pc : seq_pc;
    end

    // Jump mux: splice the preserved PC bits onto the target.
    always_comb begin
        next_pc = jump_en ? {pc_q[WORD_W-1:TGT_W], target} : after_br;
    end
endmodule

// File: rtl/pc_sequencer.sv
// Module pc_sequencer
// Top of the next-PC unit: a word-address PC register, the sequential and
// branch adders, and the branch/jump selection. The byte address is the
// word address followed by zero bits. Assumes the controls are valid for
// the instruction currently presented on instr.
module pc_sequencer
    import pcseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic               branch_en,
    input  logic               jump_en,
    input  logic               alu_zero,
    output logic [ADDR_W-1:0]  imem_addr
);
    logic [WORD_W-1:0] pc_q;
    logic [WORD_W-1:0] seq_pc;
    logic [WORD_W-1:0] br_pc;
    logic [WORD_W-1:0] next_pc;
    logic [IMM_W-1:0]  imm;
    logic [TGT_W-1:0]  target;

    // Pick the offset and target fields out of the instruction.
    always_comb begin
        imm    = instr[IMM_W-1:0];
        target = instr[TGT_W-1:0];
    end

    pc_adders #(.WORD_W(WORD_W), .IMM_W(IMM_W)) adders_i (
        .pc_q   (pc_q),
        .imm    (imm),
        .seq_pc (seq_pc),
        .br_pc  (br_pc)
    );

    pc_next_sel #(.WORD_W(WORD_W), .TGT_W(TGT_W)) sel_i (
        .pc_q      (pc_q),
        .seq_pc    (seq_pc),
        .br_pc     (br_pc),
        .target    (target),
        .branch_en (branch_en),
        .alu_zero  (alu_zero),
        .jump_en   (jump_en),
        .next_pc   (next_pc)
    );

    pc_word_reg #(.WORD_W(WORD_W)) reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .next_pc (next_pc),
        .pc_q    (pc_q)
    );

    // Form the byte address from the word address.
    always_comb begin
        imem_addr = {pc_q, {BYTE_SEL_W{1'b0}}};
    end

    // R3: with no control asserted, the PC steps by one word
    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!branch_en && !jump_en) |=> pc_q == $past(pc_q) + WORD_W'(1));

    // R5: a qualified branch adds the sign-extended offset after the step
    assert_branch_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_en && alu_zero && !jump_en) |=>
        pc_q == $past(pc_q) + WORD_W'(1)
                + {{(WORD_W-IMM_W){$past(instr[IMM_W-1])}}, $past(instr[IMM_W-1:0])});

    // R6: a jump keeps the upper PC bits and loads the target
    assert_jump_splice_R6: assert property (@(posedge clk) disable iff (!rst_n)
        jump_en |=> pc_q[WORD_W-1:TGT_W] == $past(pc_q[WORD_W-1:TGT_W]));

    // R7: a jump wins over a taken branch
    assert_jump_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_en && branch_en && alu_zero) |=>
        pc_q[TGT_W-1:0] == $past(instr[TGT_W-1:0]));
endmodule

// File: tb/pc_sequencer_tb_top.sv
// Directed bench for pc_sequencer: one task per scenario, each checking
// its own results against values worked out from the requirements.
module pc_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;
    logic        branch_en = 1'b0;
    logic        jump_en = 1'b0;
    logic        alu_zero = 1'b0;
    logic [31:0] imem_addr;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_addr;

    pc_sequencer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr     (instr),
        .branch_en (branch_en),
        .jump_en   (jump_en),
        .alu_zero  (alu_zero),
        .imem_addr (imem_addr)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Present controls 1 ns after an edge, clock once, settle 1 ns.
    task automatic step(input logic br, input logic jp, input logic zr, input logic [31:0] ins);
        branch_en = br;
        jump_en   = jp;
        alu_zero  = zr;
        instr     = ins;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] br_target(input logic [31:0] cur, input logic [15:0] off);
        return cur + 32'd4 + {{14{off[15]}}, off, 2'b00};
    endfunction

    task automatic t_reset;
        rst_n = 1'b0;
        step(1'b1, 1'b1, 1'b1, 32'h03FF_FFFF);
        check("R1 reset with controls active", imem_addr, 32'h0);
        step(1'b0, 1'b0, 1'b0, 32'h0);
        check("R2 low bits after reset", {30'h0, imem_addr[1:0]}, 32'h0);
        rst_n = 1'b1;
        exp_addr = 32'h0;
    endtask

    task automatic t_sequential;
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0, 1'b0, 32'hFC00_1234);
            exp_addr = exp_addr + 32'd4;
            check("R3 sequential step", imem_addr, exp_addr);
        end
        check("R2 byte alignment", {30'h0, imem_addr[1:0]}, 32'h0);
    endtask

    task automatic t_not_taken;
        step(1'b1, 1'b0, 1'b0, 32'h1000_0007);
        exp_addr = exp_addr + 32'd4;
        check("R4 branch with zero low", imem_addr, exp_addr);
        step(1'b0, 1'b0, 1'b1, 32'h1000_0007);
        exp_addr = exp_addr + 32'd4;
        check("R8 zero without branch", imem_addr, exp_addr);
    endtask

    task automatic t_taken;
        step(1'b1, 1'b0, 1'b1, 32'h1000_0005);
        exp_addr = br_target(exp_addr, 16'h0005);
        check("R5 forward branch", imem_addr, exp_addr);
        step(1'b1, 1'b0, 1'b1, 32'h1000_FFFD);
        exp_addr = br_target(exp_addr, 16'hFFFD);
        check("R5 backward branch", imem_addr, exp_addr);
    endtask

    task automatic t_jump;
        step(1'b0, 1'b1, 1'b0, 32'h0800_0123);
        exp_addr = {exp_addr[31:28], 26'h0000123, 2'b00};
        check("R6 jump low region", imem_addr, exp_addr);
        check("R6 jump absolute value", imem_addr, 32'h0000_048C);
    endtask

    task automatic t_priority;
        step(1'b1, 1'b1, 1'b1, 32'h0800_0040);
        exp_addr = {exp_addr[31:28], 26'h0000040, 2'b00};
        check("R7 jump beats taken branch", imem_addr, 32'h0000_0100);
    endtask

    task automatic t_wrap;
        step(1'b1, 1'b0, 1'b1, 32'h1000_FFBE);
        exp_addr = br_target(exp_addr, 16'hFFBE);
        check("R9 branch to top word", imem_addr, 32'hFFFF_FFFC);
        step(1'b0, 1'b0, 1'b0, 32'h0);
        check("R9 sequential wrap", imem_addr, 32'h0000_0000);
        exp_addr = 32'h0;
    endtask

    task automatic t_upper_keep;
        step(1'b1, 1'b0, 1'b1, 32'h1000_8000);
        exp_addr = br_target(exp_addr, 16'h8000);
        check("R5 most negative offset", imem_addr, 32'hFFFE_0004);
        step(1'b0, 1'b1, 1'b0, 32'h0800_0010);
        check("R6 jump keeps upper nibble", imem_addr, 32'hF000_0040);
        exp_addr = 32'hF000_0040;
    endtask

    task automatic t_reset_mid;
        rst_n = 1'b0;
        step(1'b0, 1'b0, 1'b0, 32'h0);
        check("R1 reset during run", imem_addr, 32'h0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 32'h0);
        check("R3 step after reset", imem_addr, 32'h4);
    endtask

    initial begin
        #(8 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_sequential();
        t_not_taken();
        t_taken();
        t_jump();
        t_priority();
        t_wrap();
        t_upper_keep();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule